// File: doc/BRIEF.md
# Multiplexed LCD Drive Sequencer

This block sequences the drive waveforms for a multiplexed liquid-crystal panel with 4 common lines and 28 segment lines, which is enough for up to 14 digits. A timer outside the block supplies a one-cycle frame tick. Each tick moves the block to the next common time slot. For every pin, the block outputs a 2-bit code that tells the external resistor ladder and buffers which rail to apply. The drive polarity reverses once per complete frame, so the panel sees no net DC.

A 3-bit mode input selects the multiplex ratio and the bias scheme. The display image comes from a flat display-memory vector holding one bit per segment per common. A display-enable input blanks the whole panel. The top 8 segment pins double as two 4-bit output ports. Each nibble has its own enable, and when that enable is set the nibble's pins carry the port latch instead of a segment waveform.

Top module: `lcd_mux_seq`

## Requirements
- R1: After reset, the slot counter is 0 and the frame polarity is positive. In static mode (mode 0) with the display enabled, COM0 then outputs code 3.
- R2: Mode decode is as follows. Mode 0 is static with 1 slot. Mode 1 is 1/2 duty with half bias. Mode 2 is 1/3 duty with half bias. Mode 3 is 1/3 duty with third bias. Mode 4 is 1/4 duty with third bias. Modes 5 to 7 are reserved, counted with 1 slot.
- R3: A frame tick advances the slot by one. On a tick in the last slot (duty-1), the slot returns to 0 and the polarity inverts. Without a tick, the polarity never changes.
- R4: Level codes are 0=VSS, 1=VLC2, 2=VLC1, 3=VLC0. COM k outputs the select level when the slot equals k and k is below the duty. Every other common, including commons unused in the current mode, outputs the non-select level. In the positive frame the common select/non-select levels are 3/1, and in the negative frame they are 0/2, for both half and third bias.
- R5: Segment s reads display bit s*4+slot. When that bit is 1, the segment drives the level opposite the selected common: code 0 in the positive frame and 3 in the negative frame. When the bit is 0, the segment drives the off level: code 2/1 (positive/negative frame) in third bias, and code 3/0 in half bias.
- R6: In static mode, every common outputs 3 in the positive frame and 0 in the negative frame. A segment whose bit is 1 outputs the opposite level, and a segment whose bit is 0 outputs the same level as the commons.
- R7: While display enable is low, every common and every non-port segment outputs code 0.
- R8: Reserved modes 5 to 7 blank the panel exactly as R7 does. Their polarity still inverts on every tick.
- R9: Port nibble 0 (enable bit 0) drives segments 27, 26, 25, 24 from latch bits 0, 1, 2, 3. Port nibble 1 (enable bit 1) drives segments 23 to 20 from latch bits 4 to 7. A driven pin outputs code 3 for a latch 1 and code 0 for a latch 0, whether the display is enabled or blanked.
- R10: If a mode change leaves the slot at or above the new duty, then until the next clock edge no common is selected. The slot then returns to 0 without a polarity change, even if a tick is present.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| frame_tick | input | 1 | One-cycle pulse that advances the common slot |
| mode | input | 3 | Duty and bias select (R2) |
| disp_on | input | 1 | Display enable; low blanks the panel |
| port_en | input | 2 | Per-nibble hand-over of shared pins to port use |
| port_latch | input | 8 | Port output latch data |
| seg_ram | input | 112 | Display bits, bit s*4+k for segment s in slot k |
| com_lvl | output | 8 | Common level codes, 2 bits per common, COM0 in bits 1:0 |
| seg_lvl | output | 56 | Segment level codes, 2 bits per segment, SEG0 in bits 1:0 |

## Verification
The hardest state to reach from the ports is the one where a slot value survives a mode change into a shorter duty, because it exists for only one clock. The stimulus reaches it deliberately: it runs 1/4 duty up to slot 3 and then switches to 1/2 duty. The outputs are checked inside that single cycle, and again after the edge, with a tick held high so that the clamp-versus-tick priority is exercised. Random phases also mix mode switches with random ticks, port enables and display data, which reaches the same state in other combinations.

// File: rtl/lcd_seq_pkg.sv
package lcd_seq_pkg;
    localparam int NCOM   = 4;
    localparam int NSEG   = 28;
    localparam int DUTY_W = $clog2(NCOM + 1);
    localparam int SLOT_W = $clog2(NCOM);

    typedef logic [1:0] lvl_t;
    localparam lvl_t LV_VSS = 2'd0;
    localparam lvl_t LV_LOW = 2'd1;
    localparam lvl_t LV_MID = 2'd2;
    localparam lvl_t LV_TOP = 2'd3;

    typedef enum logic [1:0] {
        BIAS_STATIC = 2'd0,
        BIAS_HALF   = 2'd1,
        BIAS_THIRD  = 2'd2
    } bias_e;

    typedef struct packed {
        logic [DUTY_W-1:0] duty;
        bias_e             bias;
        logic              blank;
    } mode_cfg_t;

    typedef struct packed {
        lvl_t com_sel;
        lvl_t com_idle;
        lvl_t seg_on;
        lvl_t seg_off;
    } drive_set_t;

    function automatic mode_cfg_t decode_mode(input logic [2:0] m);
        mode_cfg_t c;
        c.duty  = DUTY_W'(1);
        c.bias  = BIAS_STATIC;
        c.blank = 1'b0;
        case (m)
            3'd0: begin c.duty = DUTY_W'(1); c.bias = BIAS_STATIC; end
            3'd1: begin c.duty = DUTY_W'(2); c.bias = BIAS_HALF;   end
            3'd2: begin c.duty = DUTY_W'(3); c.bias = BIAS_HALF;   end
            3'd3: begin c.duty = DUTY_W'(3); c.bias = BIAS_THIRD;  end
            3'd4: begin c.duty = DUTY_W'(4); c.bias = BIAS_THIRD;  end
            default: c.blank = 1'b1;
        endcase
        return c;
    endfunction
endpackage

// File: rtl/lcd_slot_timer.sv
module lcd_slot_timer
    import lcd_seq_pkg::*;
#(
    parameter int N_COM   = NCOM,
    parameter int S_W     = SLOT_W,
    parameter int D_W     = DUTY_W
) (
    input  logic           clk,
    input  logic           rst_n,
    input  logic           frame_tick,
    input  logic [D_W-1:0] duty,
    output logic [S_W-1:0] slot_o,
    output logic           pol_o
);
    typedef struct packed {
        logic [S_W-1:0] slot;
        logic           pol;
    } tstate_t;

    tstate_t st_d, st_q;
    logic [D_W-1:0] slot_ext;

    always_comb begin
        st_d     = st_q;
        slot_ext = D_W'(st_q.slot);
        if (slot_ext >= duty) begin
            // slot left outside the new duty by a mode change: restart, keep polarity
            st_d.slot = '0;
        end else if (frame_tick) begin
            if (slot_ext == duty - D_W'(1)) begin
                st_d.slot = '0;
                st_d.pol  = ~st_q.pol;
            end else begin
                st_d.slot = st_q.slot + S_W'(1);
            end
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) st_q <= '0;
        else        st_q <= st_d;
    end

    assign slot_o = st_q.slot;
    assign pol_o  = st_q.pol;
endmodule

// File: rtl/lcd_drive_table.sv
module lcd_drive_table
    import lcd_seq_pkg::*;
(
    input  bias_e      bias,
    input  logic       pol,
    output drive_set_t drv
);
    drive_set_t pos;

    always_comb begin
        // positive-frame levels; the negative frame mirrors every rail
        case (bias)
            BIAS_HALF:  pos = '{com_sel: LV_TOP, com_idle: LV_LOW, seg_on: LV_VSS, seg_off: LV_TOP};
            BIAS_THIRD: pos = '{com_sel: LV_TOP, com_idle: LV_LOW, seg_on: LV_VSS, seg_off: LV_MID};
            default:    pos = '{com_sel: LV_TOP, com_idle: LV_TOP, seg_on: LV_VSS, seg_off: LV_TOP};
        endcase
        if (pol) begin
            drv.com_sel  = ~pos.com_sel;
            drv.com_idle = ~pos.com_idle;
            drv.seg_on   = ~pos.seg_on;
            drv.seg_off  = ~pos.seg_off;
        end else begin
            drv = pos;
        end
    end
endmodule

// File: rtl/lcd_seg_lane.sv
module lcd_seg_lane
    import lcd_seq_pkg::*;
#(
    parameter int N_COM = NCOM,
    parameter int S_W   = SLOT_W
) (
    input  logic [N_COM-1:0] ram_bits,
    input  logic [S_W-1:0]   slot,
    input  logic             blank,
    input  drive_set_t       drv,
    input  logic             port_on,
    input  logic             port_bit,
    output lvl_t             lvl
);
    logic lit;

    always_comb begin
        lit = ram_bits[slot];
        if (port_on)    lvl = {2{port_bit}};
        else if (blank) lvl = LV_VSS;
        else if (lit)   lvl = drv.seg_on;
        else            lvl = drv.seg_off;
    end
endmodule

// File: rtl/lcd_mux_seq.sv
module lcd_mux_seq
    import lcd_seq_pkg::*;
#(
    parameter int N_COM      = NCOM,
    parameter int N_SEG      = NSEG,
    parameter int SHARE_BASE = 20,
    parameter int NIB_W      = 4
) (
    input  logic                   clk,
    input  logic                   rst_n,
    input  logic                   frame_tick,
    input  logic [2:0]             mode,
    input  logic                   disp_on,
    input  logic [1:0]             port_en,
    input  logic [7:0]             port_latch,
    input  logic [N_SEG*N_COM-1:0] seg_ram,
    output logic [2*N_COM-1:0]     com_lvl,
    output logic [2*N_SEG-1:0]     seg_lvl
);
    localparam int S_W = $clog2(N_COM);
    localparam int D_W = $clog2(N_COM + 1);

    mode_cfg_t      cfg;
    logic [S_W-1:0] slot_q;
    logic           pol_q;
    logic           blank;
    drive_set_t     drv;

    always_comb begin
        cfg   = decode_mode(mode);
        blank = cfg.blank | ~disp_on;
    end

    lcd_slot_timer #(.N_COM(N_COM), .S_W(S_W), .D_W(D_W)) i_timer (
        .clk        (clk),
        .rst_n      (rst_n),
        .frame_tick (frame_tick),
        .duty       (cfg.duty),
        .slot_o     (slot_q),
        .pol_o      (pol_q)
    );

    lcd_drive_table i_table (
        .bias (cfg.bias),
        .pol  (pol_q),
        .drv  (drv)
    );

    for (genvar k = 0; k < N_COM; k++) begin : g_com
        logic sel;
        always_comb begin
            sel = (slot_q == S_W'(k)) && (D_W'(k) < cfg.duty);
            if (blank)    com_lvl[2*k +: 2] = LV_VSS;
            else if (sel) com_lvl[2*k +: 2] = drv.com_sel;
            else          com_lvl[2*k +: 2] = drv.com_idle;
        end
    end

    for (genvar s = 0; s < N_SEG; s++) begin : g_seg
        logic port_on;
        logic port_bit;
        if (s >= SHARE_BASE) begin : g_shared
            // port bit order runs downward from the top segment
            localparam int PB = N_SEG - 1 - s;
            assign port_on  = port_en[PB / NIB_W];
            assign port_bit = port_latch[PB];
        end else begin : g_plain
            assign port_on  = 1'b0;
            assign port_bit = 1'b0;
        end
        lcd_seg_lane #(.N_COM(N_COM), .S_W(S_W)) i_lane (
            .ram_bits (seg_ram[s*N_COM +: N_COM]),
            .slot     (slot_q),
            .blank    (blank),
            .drv      (drv),
            .port_on  (port_on),
            .port_bit (port_bit),
            .lvl      (seg_lvl[2*s +: 2])
        );
    end
endmodule

// File: rtl/lcd_mux_seq_chk.sv
module lcd_mux_seq_chk
    import lcd_seq_pkg::*;
(
    input logic              clk,
    input logic              rst_n,
    input logic              frame_tick,
    input logic [2:0]        mode,
    input logic              disp_on,
    input logic              port_en0,
    input logic              latch0,
    input logic [7:0]        com_lvl,
    input logic [1:0]        pin27,
    input logic [SLOT_W-1:0] slot_q,
    input logic              pol_q
);
    mode_cfg_t c;
    logic [DUTY_W-1:0] sx;
    always_comb begin
        c  = decode_mode(mode);
        sx = DUTY_W'(slot_q);
    end

    p_clamp_r10: assert property (@(posedge clk) disable iff (!rst_n)
        (sx >= c.duty) |=> (slot_q == '0 && $stable(pol_q)));

    p_wrap_r3: assert property (@(posedge clk) disable iff (!rst_n)
        (frame_tick && sx == c.duty - DUTY_W'(1)) |=> (slot_q == '0 && pol_q != $past(pol_q)));

    p_pol_hold_r3: assert property (@(posedge clk) disable iff (!rst_n)
        (!frame_tick) |=> $stable(pol_q));

    p_blank_r7: assert property (@(posedge clk) disable iff (!rst_n)
        (!disp_on) |-> (com_lvl == '0));

    p_port_pin_r9: assert property (@(posedge clk) disable iff (!rst_n)
        port_en0 |-> (pin27 == {2{latch0}}));
endmodule

bind lcd_mux_seq lcd_mux_seq_chk i_chk (
    .clk        (clk),
    .rst_n      (rst_n),
    .frame_tick (frame_tick),
    .mode       (mode),
    .disp_on    (disp_on),
    .port_en0   (port_en[0]),
    .latch0     (port_latch[0]),
    .com_lvl    (com_lvl),
    .pin27      (seg_lvl[55:54]),
    .slot_q     (slot_q),
    .pol_q      (pol_q)
);

// File: tb/test_lcd_mux_seq.sv
`timescale 1ns/1ps
module test_lcd_mux_seq;
    logic         clk = 1'b0;
    logic         rst_n = 1'b0;
    logic         frame_tick = 1'b0;
    logic [2:0]   mode = 3'd0;
    logic         disp_on = 1'b1;
    logic [1:0]   port_en = 2'b00;
    logic [7:0]   port_latch = 8'h00;
    logic [111:0] seg_ram = '0;
    logic [7:0]   com_lvl;
    logic [55:0]  seg_lvl;

    int errors = 0;
    int checks = 0;
    int m_slot = 0;
    bit m_pol  = 1'b0;

    always #4 clk = ~clk;

    lcd_mux_seq i_lcd_mux_seq (
        .clk(clk), .rst_n(rst_n), .frame_tick(frame_tick), .mode(mode),
        .disp_on(disp_on), .port_en(port_en), .port_latch(port_latch),
        .seg_ram(seg_ram), .com_lvl(com_lvl), .seg_lvl(seg_lvl)
    );

    // R2 mode table
    function automatic int duty_of(input logic [2:0] m);
        case (m) 3'd1: return 2; 3'd2, 3'd3: return 3; 3'd4: return 4; default: return 1; endcase
    endfunction
    function automatic int bias_of(input logic [2:0] m); // 0 static, 2 half, 3 third
        case (m) 3'd1, 3'd2: return 2; 3'd3, 3'd4: return 3; default: return 0; endcase
    endfunction

    // R4/R5/R6 level table; kind 0 com sel, 1 com idle, 2 seg on, 3 seg off
    function automatic logic [1:0] lvl_of(input int b, input bit p, input int kind);
        if (kind == 0) return p ? 2'd0 : 2'd3;
        if (kind == 2) return p ? 2'd3 : 2'd0;
        if (kind == 1) begin
            if (b == 0) return p ? 2'd0 : 2'd3;
            return p ? 2'd2 : 2'd1;
        end
        if (b == 3) return p ? 2'd1 : 2'd2;
        return p ? 2'd0 : 2'd3;
    endfunction

    function automatic logic [7:0] exp_com();
        logic [7:0] v;
        bit blank = (mode > 3'd4) || !disp_on;
        for (int k = 0; k < 4; k++) begin
            if (blank) v[2*k +: 2] = 2'd0;
            else if (k == m_slot && k < duty_of(mode)) v[2*k +: 2] = lvl_of(bias_of(mode), m_pol, 0);
            else v[2*k +: 2] = lvl_of(bias_of(mode), m_pol, 1);
        end
        return v;
    endfunction

    function automatic logic [55:0] exp_seg();
        logic [55:0] v;
        bit blank = (mode > 3'd4) || !disp_on;
        for (int s = 0; s < 28; s++) begin
            if (s >= 20 && port_en[(27 - s) / 4]) v[2*s +: 2] = {2{port_latch[27 - s]}};
            else if (blank) v[2*s +: 2] = 2'd0;
            else if (seg_ram[s*4 + m_slot]) v[2*s +: 2] = lvl_of(bias_of(mode), m_pol, 2);
            else v[2*s +: 2] = lvl_of(bias_of(mode), m_pol, 3);
        end
        return v;
    endfunction

    task automatic check_all(input string req);
        logic [7:0]  ec = exp_com();
        logic [55:0] es = exp_seg();
        checks += 2;
        if (com_lvl !== ec) begin
            errors++;
            $display("FAIL %s com_lvl actual=%h expected=%h", req, com_lvl, ec);
        end
        if (seg_lvl !== es) begin
            errors++;
            $display("FAIL %s seg_lvl actual=%h expected=%h", req, seg_lvl, es);
        end
    endtask

    // one clock; the model advances with the design's rule (R3, R10)
    task automatic cycle(input bit tk);
        int d;
        frame_tick = tk;
        @(posedge clk);
        d = duty_of(mode);
        if (m_slot >= d) m_slot = 0;
        else if (tk) begin
            if (m_slot == d - 1) begin m_slot = 0; m_pol = ~m_pol; end
            else m_slot++;
        end
        #2;
        frame_tick = 1'b0;
    endtask

    task automatic rand_ram();
        for (int i = 0; i < 4; i++) seg_ram[i*28 +: 28] = 28'($urandom);
    endtask

    initial begin
        repeat (200000) @(posedge clk);
        errors++;
        $display("FAIL watchdog expired");
        $display("Result: errors=%0d of %0d checks", errors, checks);
        $finish;
    end

    initial begin
        void'($urandom(32'd4242));
        rand_ram();
        repeat (3) @(posedge clk);
        #2 rst_n = 1'b1;
        #1 check_all("R1");
        checks++;
        if (com_lvl[1:0] !== 2'd3) begin
            errors++; $display("FAIL R1 com0 actual=%0d expected=3", com_lvl[1:0]);
        end

        // R6 static: polarity flips every tick
        for (int i = 0; i < 4; i++) begin
            cycle(1'b1); check_all("R6");
        end
        cycle(1'b0); check_all("R3");

        // R4/R5 each duty mode through more than two frames
        for (int m = 1; m <= 4; m++) begin
            mode = 3'(m); rand_ram();
            cycle(1'b0); check_all("R2");
            for (int i = 0; i < 2 * m + 3; i++) begin
                cycle(1'b1); check_all("R4"); check_all("R5");
                cycle(1'b0); check_all("R3");
            end
        end

        // R10: leave 1/4 duty at slot 3, switch to 1/2 duty
        mode = 3'd4;
        while (m_slot != 3) cycle(1'b1);
        check_all("R4");
        mode = 3'd1; #1;
        check_all("R10");
        cycle(1'b1);
        check_all("R10");
        checks++;
        if (com_lvl[1:0] !== lvl_of(2, m_pol, 0)) begin
            errors++; $display("FAIL R10 com0 actual=%0d expected=%0d", com_lvl[1:0], lvl_of(2, m_pol, 0));
        end

        // R7 display off, R9 ports on while blanked
        mode = 3'd3; disp_on = 1'b0; #1; check_all("R7");
        port_en = 2'b01; port_latch = 8'hA5; #1; check_all("R9");
        port_en = 2'b10; #1; check_all("R9");
        port_en = 2'b11; port_latch = 8'h3C; cycle(1'b1); check_all("R9");
        disp_on = 1'b1; port_en = 2'b00; #1; check_all("R9");

        // R8 reserved modes blank and still flip polarity
        for (int m = 5; m <= 7; m++) begin
            mode = 3'(m); cycle(1'b1); check_all("R8");
        end
        mode = 3'd0; cycle(1'b0); check_all("R8");

        // random mix
        for (int i = 0; i < 400; i++) begin
            if ($urandom_range(0, 15) == 0) mode = 3'($urandom_range(0, 7));
            if ($urandom_range(0, 7) == 0) rand_ram();
            if ($urandom_range(0, 9) == 0) port_en = 2'($urandom);
            if ($urandom_range(0, 9) == 0) port_latch = 8'($urandom);
            disp_on = ($urandom_range(0, 9) != 0);
            #1 check_all("R5");
            cycle(1'($urandom_range(0, 1)));
            check_all("R4");
        end

        $display("Result: errors=%0d of %0d checks", errors, checks);
        $finish;
    end
endmodule